// File: doc/BRIEF.md
# Indexed-Window Interrupt Routing Register Block

This block holds the configuration state of an I/O interrupt routing controller. A simple bus slave sees only two 32-bit locations. The first is a select register. The second is a data window onto whichever internal register the select value names. Software first writes the select value, then reads or writes the window.

The internal registers are:
- a 4-bit controller identifier;
- a read-only version word that also reports how many routing entries exist;
- a 4-bit arbitration identifier;
- a table of 64-bit routing entries, each reached as two 32-bit halves.

The routing logic reads the whole table through a separate combinational read port.

A write to a table half clears the reserved bits of that half. Only defined fields can therefore hold ones.

Every request is answered one cycle later with a single-cycle ready pulse, registered read data and an error bit. Select values that name no register are answered without error but raise a separate one-cycle flag.

Top module: `irq_route_regs`

## Requirements
- R1: A full-width write at bus offset 0x00 loads the select register from data bits 7:0. A read at offset 0x00 returns the select value in bits 7:0, with zeros above.
- R2: A request is illegal if its byte enables are not 4'hF, or if its offset is neither 0x00 nor 0x10. An illegal request returns error=1 and read data 0, and it changes no state.
- R3: Select 0x00 is the identifier register. A write loads the identifier from data bits 27:24. A read returns the identifier in bits 27:24 and zeros elsewhere.
- R4: Select 0x01 is the version word. It reads as ((NUM_ENTRIES-1)<<16) | 0x14, which is 0x00170014 for 24 entries. Writes to it have no effect.
- R5: Select 0x02 is the arbitration identifier. It is written and read through bits 27:24, like R3, and it is independent of the identifier.
- R6: Select values from 0x10 upward address table entry (select-0x10)/2. An even select value addresses bits 31:0 of that entry and an odd one addresses bits 63:32.
- R7: A write to a low half stores data bits 16:0 and clears entry bits 31:17.
- R8: A write to a high half stores data bits 31:24 in entry bits 63:56 and clears entry bits 55:32.
- R9: After reset the select register is 0, both identifiers equal RESET_ID, and every table entry is zero.
- R10: A select value that is not 0x00–0x02 and not 0x10–(0x10+2*NUM_ENTRIES-1) is undefined. A window access to it reads 0, changes nothing, and raises the undefined flag together with ready for one cycle.
- R11: Every request cycle is followed, on the next cycle, by exactly one ready cycle. Ready is never asserted without a request in the cycle before.
- R12: The table read port returns, in the same cycle, the entry named by its index input. An index of NUM_ENTRIES or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset within the block |
| req_be | input | 4 | Byte enables, must be 4'hF |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Illegal access indication |
| rsp_undef | output | 1 | Undefined select value indication |
| tbl_idx | input | 5 | Table read port entry index |
| tbl_entry | output | 64 | Table read port entry contents |

## Verification
The bench builds the block with the default 24 entries and RESET_ID set to 5. A non-zero reset identifier makes the reset values of both identifiers visible and distinguishable from cleared state. With 24 entries, the last table select value is 0x3F and the first undefined one above the table is 0x40, so both edges of the table range are exercised. The read-port index 24 tests the out-of-range case, and the version word is expected to read 0x00170014.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NUM_ENTRIES = 24,
  parameter logic [3:0] RESET_ID = 4'h0,
  parameter logic [7:0] VERSION = 8'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        rsp_undef,
  input  logic [$clog2(NUM_ENTRIES)-1:0] tbl_idx,
  output logic [63:0] tbl_entry
);
  localparam int EW = $clog2(NUM_ENTRIES);
  localparam logic [7:0] TBL_FIRST = 8'h10;
  localparam logic [7:0] TBL_LAST = 8'(16 + 2 * NUM_ENTRIES - 1);
  localparam logic [31:0] VER_WORD = (32'(NUM_ENTRIES - 1) << 16) | {24'b0, VERSION};

  logic [7:0]  sel;
  logic [3:0]  id_q, arb_q;
  logic [63:0] tbl [NUM_ENTRIES];

  logic        bad, in_tbl, known, win_wr;
  logic [7:0]  rel;
  logic [EW-1:0] ent;
  logic [31:0] win_rd;

  assign bad    = (req_be != 4'hF) || (req_addr != 8'h00 && req_addr != 8'h10);
  assign in_tbl = (sel >= TBL_FIRST) && (sel <= TBL_LAST);
  assign known  = (sel <= 8'h02) || in_tbl;
  assign rel    = sel - TBL_FIRST;
  assign ent    = rel[EW:1];
  assign win_wr = req_valid && req_write && !bad && req_addr == 8'h10;

  always_comb begin
    win_rd = '0;
    if (sel == 8'h00)      win_rd = {4'b0, id_q, 24'b0};
    else if (sel == 8'h01) win_rd = VER_WORD;
    else if (sel == 8'h02) win_rd = {4'b0, arb_q, 24'b0};
    else if (in_tbl)       win_rd = rel[0] ? tbl[ent][63:32] : tbl[ent][31:0];
  end

  assign tbl_entry = (32'(tbl_idx) < NUM_ENTRIES) ? tbl[tbl_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= '0;
      id_q  <= RESET_ID;
      arb_q <= RESET_ID;
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else begin
      if (req_valid && req_write && !bad && req_addr == 8'h00) sel <= req_wdata[7:0];
      if (win_wr) begin
        if (sel == 8'h00)      id_q  <= req_wdata[27:24];
        else if (sel == 8'h02) arb_q <= req_wdata[27:24];
        else if (in_tbl) begin
          if (rel[0]) tbl[ent][63:32] <= {req_wdata[31:24], 24'b0};
          else        tbl[ent][31:0]  <= {15'b0, req_wdata[16:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_ready <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_undef <= req_valid && !bad && req_addr == 8'h10 && !known;
      rsp_rdata <= '0;
      if (req_valid && !req_write && !bad)
        rsp_rdata <= (req_addr == 8'h00) ? {24'b0, sel} : win_rd;
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int EW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [7:0]    req_addr,
  input logic [3:0]    req_be,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic          rsp_err,
  input logic          rsp_undef,
  input logic [EW-1:0] tbl_idx,
  input logic [63:0]   tbl_entry
);
  logic bad_req;
  assign bad_req = req_valid && (req_be != 4'hF || (req_addr != 8'h00 && req_addr != 8'h10));

  p_ready_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  p_ready_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  p_err_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_err) |-> rsp_rdata == 32'h0);
  p_bad_keeps_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> (tbl_idx != $past(tbl_idx)) || $stable(tbl_entry));
  p_undef_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_undef |-> (rsp_ready && !rsp_err && rsp_rdata == 32'h0));
  p_err_only_on_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ready);
endmodule

bind irq_route_regs irq_route_regs_chk #(.EW(EW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_be(req_be), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .rsp_undef(rsp_undef), .tbl_idx(tbl_idx),
  .tbl_entry(tbl_entry)
);

// File: tb/irq_route_regs_tb_top.sv
`timescale 1ns/1ps
module irq_route_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready, rsp_err, rsp_undef;
  logic [31:0] rsp_rdata;
  logic [4:0] tbl_idx = '0;
  logic [63:0] tbl_entry;

  int total = 0, bad = 0;
  logic got_rdy, got_err, got_undef;
  logic [31:0] got_data;

  always #2.5 clk = ~clk;

  irq_route_regs #(.NUM_ENTRIES(24), .RESET_ID(4'h5)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got_rdy = rsp_ready; got_err = rsp_err; got_undef = rsp_undef; got_data = rsp_rdata;
    chk("R11 ready after request", {63'b0, got_rdy}, 64'd1);
    @(negedge clk);
    chk("R11 ready single cycle", {63'b0, rsp_ready}, 64'd0);
  endtask

  task automatic win_read(input logic [7:0] s, input string req, input logic [31:0] exp);
    acc(1'b1, 8'h00, 4'hF, {24'b0, s});
    acc(1'b0, 8'h10, 4'hF, 32'h0);
    chk(req, {32'b0, got_data}, {32'b0, exp});
  endtask

  task automatic win_write(input logic [7:0] s, input logic [31:0] d);
    acc(1'b1, 8'h00, 4'hF, {24'b0, s});
    acc(1'b1, 8'h10, 4'hF, d);
  endtask

  task automatic t_reset;
    acc(1'b0, 8'h00, 4'hF, 32'h0);
    chk("R9 select resets to 0", {32'b0, got_data}, 64'h0);
    win_read(8'h00, "R9 id reset", 32'h0500_0000);
    win_read(8'h02, "R9 arb reset", 32'h0500_0000);
    for (int i = 0; i < 24; i++) begin
      tbl_idx = 5'(i);
      #1 chk("R9 entry reset zero", tbl_entry, 64'h0);
    end
  endtask

  task automatic t_select;
    acc(1'b1, 8'h00, 4'hF, 32'hFFFF_FFA7);
    acc(1'b0, 8'h00, 4'hF, 32'h0);
    chk("R1 select readback", {32'b0, got_data}, 64'h0000_00A7);
  endtask

  task automatic t_ids;
    win_write(8'h00, 32'hFABC_DEF0);
    win_read(8'h00, "R3 id from bits 27:24", 32'h0A00_0000);
    win_read(8'h01, "R4 version word", 32'h0017_0014);
    win_write(8'h01, 32'hFFFF_FFFF);
    win_read(8'h01, "R4 version ignores write", 32'h0017_0014);
    win_write(8'h02, 32'hF3FF_FFFF);
    win_read(8'h02, "R5 arb from bits 27:24", 32'h0300_0000);
    win_read(8'h00, "R5 id independent of arb", 32'h0A00_0000);
  endtask

  task automatic t_table;
    win_write(8'h10, 32'hFFFF_FFFF);
    win_read(8'h10, "R7 low half clears 31:17", 32'h0001_FFFF);
    win_write(8'h11, 32'hFFFF_FFFF);
    win_read(8'h11, "R8 high half clears 55:32", 32'hFF00_0000);
    tbl_idx = 5'd0;
    #1 chk("R12 entry 0 on read port", tbl_entry, 64'hFF00_0000_0001_FFFF);
    tbl_idx = 5'd1;
    #1 chk("R6 neighbour entry untouched", tbl_entry, 64'h0);
    win_write(8'h3E, 32'h1234_5678);
    win_write(8'h3F, 32'hAB12_3456);
    tbl_idx = 5'd23;
    #1 chk("R6 last entry mapping", tbl_entry, 64'hAB00_0000_0000_5678);
    win_read(8'h3F, "R6 odd select high half", 32'hAB00_0000);
    tbl_idx = 5'd24;
    #1 chk("R12 out of range index", tbl_entry, 64'h0);
  endtask

  task automatic t_undef;
    win_write(8'h40, 32'hFFFF_FFFF);
    chk("R10 undef flag on write", {63'b0, got_undef}, 64'd1);
    chk("R10 undef no error", {63'b0, got_err}, 64'd0);
    win_read(8'h40, "R10 undef reads zero", 32'h0);
    win_read(8'h03, "R10 select 3 reads zero", 32'h0);
    chk("R10 undef flag on read", {63'b0, got_undef}, 64'd1);
    tbl_idx = 5'd23;
    #1 chk("R10 table untouched", tbl_entry, 64'hAB00_0000_0000_5678);
    win_read(8'h02, "R10 defined select no flag", 32'h0300_0000);
    chk("R10 no flag on defined", {63'b0, got_undef}, 64'd0);
  endtask

  task automatic t_illegal;
    acc(1'b1, 8'h00, 4'hF, 32'h0000_0010);
    acc(1'b1, 8'h04, 4'hF, 32'h0000_0011);
    chk("R2 bad offset error", {63'b0, got_err}, 64'd1);
    acc(1'b1, 8'h00, 4'h3, 32'h0000_0002);
    chk("R2 partial enable error", {63'b0, got_err}, 64'd1);
    acc(1'b1, 8'h10, 4'h1, 32'h0000_0000);
    chk("R2 partial window write error", {63'b0, got_err}, 64'd1);
    acc(1'b0, 8'h00, 4'hF, 32'h0);
    chk("R2 select unchanged", {32'b0, got_data}, 64'h10);
    chk("R2 legal access no error", {63'b0, got_err}, 64'd0);
    acc(1'b0, 8'h10, 4'hF, 32'h0);
    chk("R2 entry 0 low unchanged", {32'b0, got_data}, 64'h0001_FFFF);
    acc(1'b0, 8'h14, 4'hF, 32'h0);
    chk("R2 bad read data zero", {32'b0, got_data}, 64'h0);
    chk("R2 bad read error", {63'b0, got_err}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 no ready in reset", {63'b0, rsp_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle no ready", {63'b0, rsp_ready}, 64'd0);
    t_reset;
    t_select;
    t_ids;
    t_table;
    t_undef;
    t_illegal;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule